// File: doc/BRIEF.md
# Serial Field-Memory Read Port

This block is the read half of a sequential field memory. A read clock steps an internal word pointer through a shared storage array. Each enabled clock delivers the next stored word on a 12-bit output register. The storage itself sits outside the block. The block reaches it through a synchronous read port with one cycle of latency. To hide that latency, the block presents the address of the word it will need at the next edge, one cycle early.

A rewind input returns the pointer to word zero. A read-enable input decides whether an edge advances the pointer and shifts out a word. An output-enable input controls only whether the output is driven, through a separate drive-enable signal. It never holds back the pointer. A read run after a rewind is expected to last at least 150 enabled cycles. That is a usage rule for whoever drives the block, and the block does not enforce it.

Top module: `srp_read_port`

## Requirements
- R1: While `rst_n` is low, the pointer is zero, `dout` is all zeros, `dout_oe` is low and the rewind input is armed.
- R2: A rising edge that sees `rewind` high while the rewind input is armed sets the pointer to zero. The next enabled edge then delivers word 0.
- R3: On a recognised rewind edge, `rd_en` and `out_en` are ignored: `dout` and `dout_oe` keep their values.
- R4: After a recognised rewind, `rewind` is armed again only after it has been sampled low on at least REARM consecutive edges (default 2). A high `rewind` that is not armed leaves the pointer alone, and that edge acts as an ordinary read edge.
- R5: An edge with `rd_en` high that is not a rewind loads `dout` with the stored word at the current pointer, unchanged in polarity, and advances the pointer by one.
- R6: An edge with `rd_en` low that is not a rewind leaves the pointer and `dout` unchanged.
- R7: On every edge that is not a rewind, `dout_oe` takes the sampled `out_en`. `out_en` has no effect on the pointer or on the value of `dout`.
- R8: When the pointer is at word DEPTH-1, an enabled edge sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, rising edge active |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rewind | input | 1 | Request to return the pointer to word zero |
| rd_en | input | 1 | Advance the pointer and shift out a word on this edge |
| out_en | input | 1 | Request to drive the output |
| mem_addr | output | AW | Address sent to the storage read port for the next edge |
| mem_rdata | input | WIDTH | Word returned by the storage, one cycle after its address |
| dout | output | WIDTH | Registered output word |
| dout_oe | output | 1 | Drive enable for the output; low means high impedance |

## Verification
The bench builds the block with DEPTH=16 and REARM=2. The small depth lets a run of only a few dozen enabled edges cross the wrap from word 15 to word 0 several times, including wraps that fall right next to a rewind. Keeping REARM at its default of 2 exercises the real re-arm window. That covers a rewind raised again after a single low cycle, a rewind held high for several edges, and a rewind raised after exactly two low cycles. All of these are checked against a behavioural pointer model, together with long stretches of random enables.

// File: rtl/srp_pkg.sv
package srp_pkg;
    // What a single read-clock edge does to the port.
    typedef enum logic [1:0] {
        SRP_HOLD   = 2'd0,
        SRP_SHIFT  = 2'd1,
        SRP_REWIND = 2'd2
    } srp_act_e;
endpackage

// File: rtl/srp_rewind_arm.sv
module srp_rewind_arm
    import srp_pkg::*;
#(
    parameter int REARM = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rewind,
    input  logic     rd_en,
    output srp_act_e act
);
    localparam int CW = $clog2(REARM + 1);
    localparam logic [CW-1:0] FULL = CW'(REARM);

    typedef struct packed {
        logic [CW-1:0] low;
    } arm_st_t;

    arm_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = rewind && (st_q.low >= FULL);
        if (rewind) begin
            st_d.low = '0;
        end else if (st_q.low < FULL) begin
            st_d.low = st_q.low + 1'b1;
        end
        if (hit) begin
            act = SRP_REWIND;
        end else if (rd_en) begin
            act = SRP_SHIFT;
        end else begin
            act = SRP_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.low <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    rearm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SRP_REWIND) |=> (act != SRP_REWIND));
endmodule

// File: rtl/srp_ptr.sv
module srp_ptr
    import srp_pkg::*;
#(
    parameter int DEPTH = 262144,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  srp_act_e      act,
    output logic [AW-1:0] ptr_q,
    output logic [AW-1:0] ptr_d
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_comb begin
        ptr_d = ptr_q;
        unique case (act)
            SRP_REWIND: ptr_d = '0;
            SRP_SHIFT:  ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            default:    ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // R2
    rewind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SRP_REWIND) |=> (ptr_q == '0));
    // R6
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SRP_HOLD) |=> $stable(ptr_q));
    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SRP_SHIFT && ptr_q == LAST) |=> (ptr_q == '0));
    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SRP_SHIFT && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/srp_out.sv
module srp_out
    import srp_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  srp_act_e         act,
    input  logic             out_en,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             oe;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act)
            SRP_REWIND: st_d = st_q;
            SRP_SHIFT: begin
                st_d.data = mem_rdata;
                st_d.oe   = out_en;
            end
            default: st_d.oe = out_en;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.data;
    assign dout_oe = st_q.oe;

    // R3
    rewind_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SRP_REWIND) |=> ($stable(dout) && $stable(dout_oe)));
    // R7
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act != SRP_REWIND) |=> (dout_oe == $past(out_en)));
    // R6
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SRP_HOLD) |=> $stable(dout));
endmodule

// File: rtl/srp_read_port.sv
module srp_read_port
    import srp_pkg::*;
#(
    parameter int WIDTH = 12,
    parameter int DEPTH = 262144,
    parameter int REARM = 2,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rewind,
    input  logic             rd_en,
    input  logic             out_en,
    output logic [AW-1:0]    mem_addr,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe
);
    srp_act_e      act;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_d;

    srp_rewind_arm #(.REARM(REARM)) u_arm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rewind (rewind),
        .rd_en  (rd_en),
        .act    (act)
    );

    srp_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .ptr_q (ptr_q),
        .ptr_d (ptr_d)
    );

    srp_out #(.WIDTH(WIDTH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .out_en    (out_en),
        .mem_rdata (mem_rdata),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    // Address the word that the next edge will shift out.
    assign mem_addr = ptr_d;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (ptr_q == '0 && dout == '0 && !dout_oe));
endmodule

// File: tb/tb_srp_read_port.sv
`timescale 1ns/1ps
module tb_srp_read_port;
    localparam int WIDTH = 12;
    localparam int DEPTH = 16;
    localparam int REARM = 2;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rewind = 1'b0;
    logic             rd_en = 1'b0;
    logic             out_en = 1'b0;
    logic [AW-1:0]    mem_addr;
    logic [WIDTH-1:0] mem_rdata = '0;
    logic [WIDTH-1:0] dout;
    logic             dout_oe;

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    int          m_ptr = 0;
    int          m_low = REARM;
    logic [WIDTH-1:0] m_dout = '0;
    logic        m_oe = 1'b0;

    always #4 clk = ~clk;

    srp_read_port #(.WIDTH(WIDTH), .DEPTH(DEPTH), .REARM(REARM)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rewind    (rewind),
        .rd_en     (rd_en),
        .out_en    (out_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    function automatic logic [WIDTH-1:0] word(input int a);
        return WIDTH'((a * 419 + 'h1A3) ^ 'hC35);
    endfunction

    // Storage with a one-cycle synchronous read.
    always @(posedge clk) mem_rdata <= word(int'(mem_addr));

    // Behavioural reference model.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_dout = '0; m_oe = 1'b0; m_low = REARM;
        end else if (rewind && m_low >= REARM) begin
            m_ptr = 0; m_low = 0;
        end else begin
            if (rewind) m_low = 0;
            else if (m_low < REARM) m_low = m_low + 1;
            if (rd_en) begin
                m_dout = word(m_ptr);
                m_ptr  = (m_ptr + 1) % DEPTH;
            end
            m_oe = out_en;
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks += 2;
            if (dout !== m_dout) begin
                errors++;
                $display("FAIL %s dout actual=%h expected=%h t=%0t", cur_req, dout, m_dout, $time);
            end
            if (dout_oe !== m_oe) begin
                errors++;
                $display("FAIL %s dout_oe actual=%b expected=%b t=%0t", cur_req, dout_oe, m_oe, $time);
            end
        end
    end

    task automatic cyc(input logic rw, input logic re, input logic oe);
        @(negedge clk);
        rewind = rw; rd_en = re; out_en = oe;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-reqs actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        chk_on = 1'b1;           // R1: reset state observed while held
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0);
        cur_req = "R2";          // first rewind, then read from word 0
        cyc(1, 1, 1);
        cyc(0, 0, 1);
        cyc(0, 0, 1);
        cur_req = "R5";
        repeat (10) cyc(0, 1, 1);
        cur_req = "R8";          // cross the wrap twice
        repeat (24) cyc(0, 1, 1);
        cur_req = "R6";
        for (int i = 0; i < 12; i++) cyc(0, i[0], 1);
        cur_req = "R7";          // pointer keeps moving with output off
        repeat (5) cyc(0, 1, 0);
        repeat (3) cyc(0, 0, 1);
        repeat (4) cyc(0, 1, 1);
        cyc(0, 0, 0);
        cur_req = "R3";          // enables ignored on the rewind edge
        cyc(0, 1, 1);
        cyc(1, 1, 0);
        cyc(0, 0, 1);
        cyc(0, 1, 1);
        cyc(1, 1, 0);
        cur_req = "R4";          // early and held rewinds ignored
        cyc(0, 1, 1);
        cyc(1, 1, 1);
        cyc(0, 1, 1);
        cyc(0, 1, 1);
        cyc(1, 1, 0);
        cyc(1, 1, 1);
        cyc(1, 1, 1);
        cyc(0, 1, 1);
        cyc(0, 0, 1);
        cyc(1, 0, 1);
        repeat (6) cyc(0, 1, 1);
        cur_req = "R5";          // random mix
        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 9) == 0, $urandom % 4 != 0, $urandom % 5 != 0);
        end
        cur_req = "R1";          // reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) cyc(1, 1, 1);
        cyc(0, 0, 0);
        rst_n = 1'b1;
        repeat (3) cyc(0, 1, 1);
        @(negedge clk);
        finish_run();
    end
endmodule